// File: doc/BRIEF.md
# Sync-Pattern Word Framer

The framer takes an already decoded serial bit stream, one bit per cycle in which `bitValid` is high, and turns it into 32-bit words for a receive FIFO. While hunting, it compares the most recent 32 bits against a programmable sync pattern after every incoming bit. When the pattern is found, the framer locks, and each following group of 32 bits becomes one data word. The first bit received becomes the MSB of the word.

While locked, the framer counts the data words since the last sync. Once `wordCount` data words have arrived, the next 32-bit group must be the sync pattern again. A matching group is consumed without being written, and the interval count restarts. A group that does not match sets a sticky frame error, drops lock and sends the framer back to hunting.

Every completed data word is offered to the FIFO with a single-cycle write strobe. If the FIFO reports full at that moment, the word is dropped and a sticky overrun flag is raised. Both flags stay set until `clearStatus` is asserted.

Top module: `syncFramer`

## Requirements
- R1: After reset, `locked`, `wordWrite`, `frameErr` and `overrunErr` are all 0.
- R2: While hunting, the framer locks in the cycle after any valid bit that makes the last 32 valid bits equal `syncWord`, whatever the bit alignment. `locked` reads 1 from then on.
- R3: While locked, each 32 valid bits form one word, and the earliest bit received is bit 31. `wordWrite` is high for exactly one cycle, in the cycle after the 32nd bit, and `wordOut` carries the word in that cycle.
- R4: After `wordCount` data words, the next 32-bit group is compared with `syncWord`. On a match, that group is not written, lock is kept, and a further `wordCount` data words are accepted.
- R5: While locked, a group equal to `syncWord` that arrives before the interval is complete is written as ordinary data.
- R6: If the group at the interval check differs from `syncWord`, `frameErr` is set, `locked` falls to 0 and no write occurs. The framer then hunts again and writes nothing until it finds a new sync.
- R7: If `fifoFull` is high in the cycle of a data word's last bit, no write occurs and `overrunErr` is set. The dropped word still counts toward the sync interval.
- R8: `frameErr` and `overrunErr` stay set until `clearStatus` is high at a clock edge. If a new error occurs at the same edge as a clear, the flag ends up set.
- R9: Cycles with `bitValid` low change no state. Neither the bit position nor the assembled word is affected by `bitIn` in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitIn | input | 1 | Decoded serial bit |
| bitValid | input | 1 | `bitIn` is a new bit this cycle |
| syncWord | input | 32 | Sync pattern to hunt for and recheck |
| wordCount | input | 16 | Data words between sync patterns |
| clearStatus | input | 1 | Clears the sticky error flags |
| fifoFull | input | 1 | Receive FIFO cannot take a word |
| wordOut | output | 32 | Assembled data word |
| wordWrite | output | 1 | One-cycle write strobe for `wordOut` |
| locked | output | 1 | Framer is locked to the sync pattern |
| frameErr | output | 1 | Sticky: sync missing at the interval check |
| overrunErr | output | 1 | Sticky: word dropped because the FIFO was full |

## Verification
The clearing of a sticky flag and the raising of a new error can land on the same clock edge. The bench provokes this by holding `fifoFull` and pulsing `clearStatus` in the cycle of a data word's last bit. The flag must read 1 afterwards, and a later clear with no event must bring it to 0. A second coincidence is the interval check on a group that happens to equal the sync pattern. The bench sends the sync value as data before the interval is complete and expects a normal write, and then sends it exactly at the interval and expects it to be consumed.

// File: rtl/framerPkg.sv
package framerPkg;
  typedef enum logic {HUNT = 1'b0, LOCK = 1'b1} frameState_t;

  typedef struct packed {
    logic startFrame;
    logic countBits;
    logic captureWord;
    logic bumpIdx;
    logic clearIdx;
  } framerStrobes_t;
endpackage

// File: rtl/framerDatapath.sv
module framerDatapath
  import framerPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitIn,
  input  logic                 bitValid,
  input  logic [WORD_W-1:0]    syncWord,
  input  logic [CNT_W-1:0]     wordCount,
  input  framerStrobes_t       strobes,
  output logic                 nextMatch,
  output logic                 lastBit,
  output logic                 idxAtLimit,
  output logic [WORD_W-1:0]    wordOut
);
  localparam int BIT_CNT_W = $clog2(WORD_W);
  localparam logic [BIT_CNT_W-1:0] LAST_POS = BIT_CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0]    shiftReg;
  logic [WORD_W-1:0]    nextShift;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0]     wordIdx;

  assign nextShift  = {shiftReg[WORD_W-2:0], bitIn};
  assign nextMatch  = (nextShift == syncWord);
  assign lastBit    = (bitCnt == LAST_POS);
  assign idxAtLimit = (wordIdx == wordCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (bitValid) shiftReg <= nextShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (strobes.startFrame) bitCnt <= '0;
    else if (strobes.countBits && bitValid) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordIdx <= '0;
    else if (strobes.startFrame || strobes.clearIdx) wordIdx <= '0;
    else if (strobes.bumpIdx) wordIdx <= wordIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordOut <= '0;
    else if (strobes.captureWord) wordOut <= nextShift;
  end

  // R9: bit position only moves on a valid bit
  assert_bitcnt_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |=> $stable(bitCnt));
  // R4: interval counter never passes the programmed limit
  assert_idx_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idxAtLimit && $stable(wordCount)) |=> (wordIdx <= wordCount));
endmodule

// File: rtl/framerControl.sv
module framerControl
  import framerPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           bitValid,
  input  logic           fifoFull,
  input  logic           clearStatus,
  input  logic           nextMatch,
  input  logic           lastBit,
  input  logic           idxAtLimit,
  output framerStrobes_t strobes,
  output logic           wordWrite,
  output logic           locked,
  output logic           frameErr,
  output logic           overrunErr
);
  frameState_t state;
  logic wordDone;
  logic frameEvt;
  logic overEvt;

  assign wordDone = (state == LOCK) && bitValid && lastBit;
  assign frameEvt = wordDone && idxAtLimit && !nextMatch;
  assign overEvt  = wordDone && !idxAtLimit && fifoFull;

  always_comb begin
    strobes = '0;
    strobes.startFrame  = (state == HUNT) && bitValid && nextMatch;
    strobes.countBits   = (state == LOCK);
    strobes.bumpIdx     = wordDone && !idxAtLimit;
    strobes.captureWord = wordDone && !idxAtLimit && !fifoFull;
    strobes.clearIdx    = wordDone && idxAtLimit && nextMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= HUNT;
    else if (strobes.startFrame) state <= LOCK;
    else if (frameEvt) state <= HUNT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordWrite <= 1'b0;
    else wordWrite <= strobes.captureWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameErr   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      frameErr   <= frameEvt || (frameErr && !clearStatus);
      overrunErr <= overEvt || (overrunErr && !clearStatus);
    end
  end

  assign locked = (state == LOCK);

  assert_write_when_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordWrite |-> $past(locked));
  assert_no_write_when_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordWrite |-> !$past(fifoFull));
  assert_frame_drops_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameErr) |-> !locked);
  assert_frame_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clearStatus) |=> frameErr);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && !clearStatus) |=> overrunErr);
  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    wordWrite |=> !wordWrite);
endmodule

// File: rtl/syncFramer.sv
module syncFramer
  import framerPkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitValid,
  input  logic [WORD_W-1:0] syncWord,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              clearStatus,
  input  logic              fifoFull,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordWrite,
  output logic              locked,
  output logic              frameErr,
  output logic              overrunErr
);
  framerStrobes_t strobes;
  logic nextMatch;
  logic lastBit;
  logic idxAtLimit;

  framerDatapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) uDatapath (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .syncWord(syncWord), .wordCount(wordCount), .strobes(strobes),
    .nextMatch(nextMatch), .lastBit(lastBit), .idxAtLimit(idxAtLimit),
    .wordOut(wordOut)
  );

  framerControl uControl (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .fifoFull(fifoFull),
    .clearStatus(clearStatus), .nextMatch(nextMatch), .lastBit(lastBit),
    .idxAtLimit(idxAtLimit), .strobes(strobes), .wordWrite(wordWrite),
    .locked(locked), .frameErr(frameErr), .overrunErr(overrunErr)
  );
endmodule

// File: tb/tb_syncFramer.sv
module tb_syncFramer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SYNC = 32'h1ACF_FC1D;

  logic        clk = 0;
  logic        rstN = 0;
  logic        bitIn = 0;
  logic        bitValid = 0;
  logic [31:0] syncWord = SYNC;
  logic [15:0] wordCount = 16'd2;
  logic        clearStatus = 0;
  logic        fifoFull = 0;
  logic [31:0] wordOut;
  logic        wordWrite;
  logic        locked;
  logic        frameErr;
  logic        overrunErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  syncFramer dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitValid(bitValid),
    .syncWord(syncWord), .wordCount(wordCount), .clearStatus(clearStatus),
    .fifoFull(fifoFull), .wordOut(wordOut), .wordWrite(wordWrite),
    .locked(locked), .frameErr(frameErr), .overrunErr(overrunErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Sends a word MSB first; optional idle gaps with toggling bitIn; samples
  // the write strobe in the cycle after the last bit.
  task automatic sendWord(input logic [31:0] w, input bit gaps, input bit full,
                          input bit clr, output logic wr, output logic [31:0] dat);
    for (int i = 31; i >= 0; i--) begin
      if (gaps && (i % 5 == 0)) begin
        @(negedge clk);
        bitValid = 0;
        bitIn = ~w[i];
      end
      @(negedge clk);
      bitIn = w[i];
      bitValid = 1;
      fifoFull = (i == 0) ? full : 1'b0;
      clearStatus = (i == 0) ? clr : 1'b0;
    end
    @(negedge clk);
    bitValid = 0;
    fifoFull = 0;
    clearStatus = 0;
    wr = wordWrite;
    dat = wordOut;
  endtask

  task automatic lockUp(input string req);
    logic wr;
    logic [31:0] d;
    sendWord(32'h0000_0000, 0, 0, 0, wr, d);
    sendWord(SYNC, 0, 0, 0, wr, d);
    check(req, {31'd0, locked}, 32'd1);
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clearStatus = 1;
    @(negedge clk);
    clearStatus = 0;
  endtask

  task automatic testReset();
    check("R1 locked", {31'd0, locked}, 32'd0);
    check("R1 wordWrite", {31'd0, wordWrite}, 32'd0);
    check("R1 frameErr", {31'd0, frameErr}, 32'd0);
    check("R1 overrunErr", {31'd0, overrunErr}, 32'd0);
  endtask

  task automatic testFraming();
    logic wr;
    logic [31:0] d;
    lockUp("R2 lock on sync");
    sendWord(32'h8000_0001, 0, 0, 0, wr, d);
    check("R3 write", {31'd0, wr}, 32'd1);
    check("R3 MSB first", d, 32'h8000_0001);
    @(negedge clk);
    check("R3 single pulse", {31'd0, wordWrite}, 32'd0);
    sendWord(32'hA5C3_0F96, 1, 0, 0, wr, d);
    check("R9 gapped word", d, 32'hA5C3_0F96);
    check("R9 gapped write", {31'd0, wr}, 32'd1);
    sendWord(SYNC, 0, 0, 0, wr, d);
    check("R4 sync not written", {31'd0, wr}, 32'd0);
    check("R4 still locked", {31'd0, locked}, 32'd1);
    check("R4 no frame error", {31'd0, frameErr}, 32'd0);
    sendWord(SYNC, 0, 0, 0, wr, d);
    check("R5 early sync written", {31'd0, wr}, 32'd1);
    check("R5 early sync data", d, SYNC);
    sendWord(32'h1234_5678, 0, 0, 0, wr, d);
    check("R4 second data", d, 32'h1234_5678);
    sendWord(32'hFFFF_0000, 0, 0, 0, wr, d);
    check("R6 no write on miss", {31'd0, wr}, 32'd0);
    check("R6 frameErr", {31'd0, frameErr}, 32'd1);
    check("R6 lock dropped", {31'd0, locked}, 32'd0);
    sendWord(32'hDEAD_BEEF, 0, 0, 0, wr, d);
    check("R6 hunting writes nothing", {31'd0, wr}, 32'd0);
    check("R8 frameErr sticky", {31'd0, frameErr}, 32'd1);
    pulseClear();
    check("R8 frameErr cleared", {31'd0, frameErr}, 32'd0);
  endtask

  task automatic testAlignment();
    logic wr;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bitIn = i[0];
      bitValid = 1;
    end
    sendWord(SYNC, 0, 0, 0, wr, d);
    check("R2 odd alignment lock", {31'd0, locked}, 32'd1);
    sendWord(32'h0F0F_1111, 0, 0, 0, wr, d);
    check("R2 aligned data", d, 32'h0F0F_1111);
  endtask

  task automatic testOverrun();
    logic wr;
    logic [31:0] d;
    sendWord(32'h3333_3333, 0, 1, 0, wr, d);
    check("R7 no write when full", {31'd0, wr}, 32'd0);
    check("R7 overrunErr", {31'd0, overrunErr}, 32'd1);
    sendWord(SYNC, 0, 0, 0, wr, d);
    check("R7 dropped word counted", {31'd0, locked & ~frameErr}, 32'd1);
    sendWord(32'h4444_4444, 0, 1, 1, wr, d);
    check("R8 set wins over clear", {31'd0, overrunErr}, 32'd1);
    sendWord(32'h5555_5555, 0, 0, 0, wr, d);
    check("R7 write resumes", d, 32'h5555_5555);
    check("R8 overrun still sticky", {31'd0, overrunErr}, 32'd1);
    pulseClear();
    check("R8 overrun cleared", {31'd0, overrunErr}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testFraming();
    testAlignment();
    testOverrun();
    finishRun();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      finishRun();
    end
  end
endmodule